// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked user port read and write an external asynchronous static RAM of 512K words by 8 bits. The user presents one request at a time (address, write data and a write flag) while `req_ready` is high; the controller runs the memory sequence and pulses `rsp_done` for one cycle when it has finished. After a read, the data stays on `rsp_rdata` until the next read completes.

The memory side has three active-low strobes (chip select, output enable, write strobe), the address lines, and a data bus split into a driven value, a drive enable and a sampled input, for a pad ring to combine. The memory has no clock, so every setup, pulse width, access time and release time is met by counting cycles of the local clock. Each phase length is the ceiling of a nanosecond minimum divided by the clock period, and is never less than one cycle. All strobes come straight from flops, so they cannot glitch.

A read holds the address with chip select and output enable low, then samples the bus on the last cycle. A write first drives address and data with the strobe high, then lowers the write strobe, raises it again one cycle before anything else changes, and only then releases chip select and the data drivers. After every read, idle cycles cover the time the memory may keep driving the bus.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst_n` is low, every clock edge leaves `mem_ce_n`, `mem_oe_n` and `mem_we_n` high, `mem_dq_oe` low and `rsp_done` low; `req_ready` is high in the first cycle after reset is released.
- R2: A read keeps `mem_ce_n` and `mem_oe_n` low, `mem_we_n` high and the address steady for RD = max(ceil(45/P), ceil(20/P)) cycles, where P is the clock period in ns (3 cycles at 20 ns). It captures the bus on the last of these cycles, and `rsp_done` rises RD edges after the edge that accepted the request.
- R3: A write drives address and data with `mem_dq_oe` high and `mem_we_n` high for one cycle, then holds `mem_we_n` low for WE = max(ceil(35/P), ceil(25/P), ceil(45/P)-2) cycles (2 at 20 ns). `mem_oe_n` stays high for the whole write, and `rsp_done` rises WE+2 edges after the accepting edge.
- R4: `mem_we_n` rises one full cycle before `mem_ce_n` rises and `mem_dq_oe` falls. Address and write data do not change between the write strobe's fall and one cycle after its rise.
- R5: `rsp_done` is high for exactly one cycle per accepted request, and `rsp_rdata` keeps the last value read until another read completes.
- R6: After a read, `req_ready` stays low for exactly TA = ceil(15/P) cycles (1 at 20 ns), counted from the cycle in which `rsp_done` is high. The data drivers do not turn on within TA cycles of `mem_oe_n` rising.
- R7: A request is accepted only on an edge where `req_ready` is high. A `req_valid` pulse while `req_ready` is low causes no memory access and no `rsp_done`.
- R8: `mem_dq_oe` is high only while `mem_oe_n` is high and `mem_ce_n` is low, so the controller and the memory never drive the bus together.
- R9: While `mem_ce_n` is high, `mem_oe_n` and `mem_we_n` are high and the data drivers are off; `mem_oe_n` is low only with `mem_ce_n` low and `mem_we_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Data for a write |
| req_ready | output | 1 | Controller idle and able to take a request |
| rsp_done | output | 1 | One-cycle pulse when a request finishes |
| rsp_rdata | output | 8 | Data of the most recent read |
| mem_addr | output | 19 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | 8 | Value for the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 8 | Sampled data bus |

## Verification
The hardest situation to bring about is a write that arrives on the first cycle the controller becomes ready after a read: this is when the bus release gap matters. The driver therefore issues each write straight after a read without idle cycles. It counts the cycles `req_ready` stays low, and the memory model measures in nanoseconds how long after `mem_oe_n` rose the drivers came on. The memory model returns a marker value unless the read controls and address have been steady for the access time, so a capture that comes too early shows up as wrong data in the scoreboard. A second hard case is a request raised while the controller is busy. The driver injects one in the middle of a write, and a later read of that address shows whether it had any effect.

// File: rtl/asram_pkg.sv
// Package: shared types and cycle arithmetic for the static RAM controller.
// Assumes all timing figures are whole nanoseconds and the period is > 0.
package asram_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD    = 3'd1,
        ST_WSET  = 3'd2,
        ST_WPUL  = 3'd3,
        ST_WHOLD = 3'd4,
        ST_TURN  = 3'd5
    } seq_state_t;

    // Cycles needed to cover ns nanoseconds, never fewer than one
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two integers
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
// Module: phase length down-counter.
// Loads a value, counts down to zero and holds there; zero_o flags the last
// cycle of a phase. Assumes load_val fits in CNT_W bits.
module asram_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: load has priority, otherwise decrement to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
// Module: read/write/turnaround sequencer with registered memory strobes.
// Assumes the phase cycle counts are at least one and fit in CNT_W bits
// after subtracting one. All strobes are flops, so none can glitch.
module asram_seq
    import asram_pkg::*;
#(
    parameter int CNT_W  = 2,
    parameter int RD_CYC = 3,
    parameter int WE_CYC = 2,
    parameter int TA_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             zero_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             accept_o,
    output logic             capture_o,
    output logic             ready_o,
    output logic             done_o,
    output logic             ce_n_o,
    output logic             oe_n_o,
    output logic             we_n_o,
    output logic             dq_oe_o
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LOAD = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

    seq_state_t state_q;

    assign ready_o   = (state_q == ST_IDLE);
    assign accept_o  = ready_o && req_valid;
    assign capture_o = (state_q == ST_RD) && zero_i;

    // Timer reload at each phase entry
    always_comb begin
        load_o     = 1'b0;
        load_val_o = '0;
        if (accept_o) begin
            load_o     = 1'b1;
            load_val_o = req_write ? '0 : RD_LOAD;
        end else if (state_q == ST_WSET) begin
            load_o     = 1'b1;
            load_val_o = WE_LOAD;
        end else if (capture_o) begin
            load_o     = 1'b1;
            load_val_o = TA_LOAD;
        end
    end

    // Phase register and memory strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ce_n_o  <= 1'b1;
            oe_n_o  <= 1'b1;
            we_n_o  <= 1'b1;
            dq_oe_o <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        ce_n_o <= 1'b0;
                        if (req_write) begin
                            state_q <= ST_WSET;
                            dq_oe_o <= 1'b1;
                        end else begin
                            state_q <= ST_RD;
                            oe_n_o  <= 1'b0;
                        end
                    end
                end
                ST_RD: begin
                    if (zero_i) begin
                        ce_n_o  <= 1'b1;
                        oe_n_o  <= 1'b1;
                        done_o  <= 1'b1;
                        state_q <= ST_TURN;
                    end
                end
                ST_WSET: begin
                    we_n_o  <= 1'b0;
                    state_q <= ST_WPUL;
                end
                ST_WPUL: begin
                    if (zero_i) begin
                        we_n_o  <= 1'b1;
                        state_q <= ST_WHOLD;
                    end
                end
                ST_WHOLD: begin
                    ce_n_o  <= 1'b1;
                    dq_oe_o <= 1'b0;
                    done_o  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_TURN: begin
                    if (zero_i)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/asram_datapath.sv
// Module: address, write data and read data registers.
// Address and write data are held from acceptance until the next request;
// read data is captured from the bus on the last read cycle.
module asram_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              is_write_i,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [DATA_W-1:0] rdata_o
);

    // Address register, loaded on every accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)
            mem_addr <= '0;
        else if (accept_i)
            mem_addr <= req_addr;
    end

    // Write data register, loaded only for writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            mem_dq_o <= '0;
        else if (accept_i && is_write_i)
            mem_dq_o <= req_wdata;
    end

    // Read data register, loaded on the last read cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= '0;
        else if (capture_i)
            rdata_o <= mem_dq_i;
    end

endmodule

// File: rtl/asram_ctrl.sv
// Module: top of the asynchronous static RAM controller.
// Converts the memory's nanosecond minimums into cycle counts for the
// given clock period and ties timer, sequencer and datapath together.
// Assumes one request at a time and that the pad ring merges the bus.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_RC_NS       = 45,
    parameter int T_AA_NS       = 45,
    parameter int T_DOE_NS      = 20,
    parameter int T_WC_NS       = 45,
    parameter int T_PWE_NS      = 35,
    parameter int T_AW_NS       = 35,
    parameter int T_SD_NS       = 25,
    parameter int T_HZ_NS       = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int P       = CLK_PERIOD_NS;
    localparam int RD_CYC  = imax(ns_to_cyc(T_RC_NS, P),
                             imax(ns_to_cyc(T_AA_NS, P), ns_to_cyc(T_DOE_NS, P)));
    localparam int WC_REST = ns_to_cyc(T_WC_NS, P) - 2;
    localparam int AW_REST = ns_to_cyc(T_AW_NS, P) - 1;
    localparam int WE_CYC  = imax(imax(ns_to_cyc(T_PWE_NS, P), ns_to_cyc(T_SD_NS, P)),
                             imax(imax(WC_REST, AW_REST), 1));
    localparam int TA_CYC  = ns_to_cyc(T_HZ_NS, P);
    localparam int CNT_MAX = imax(RD_CYC, imax(WE_CYC, TA_CYC));
    localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

    logic             zero;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             accept;
    logic             capture;

    asram_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .zero_o   (zero)
    );

    asram_seq #(
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .WE_CYC (WE_CYC),
        .TA_CYC (TA_CYC)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .zero_i     (zero),
        .load_o     (load),
        .load_val_o (load_val),
        .accept_o   (accept),
        .capture_o  (capture),
        .ready_o    (req_ready),
        .done_o     (rsp_done),
        .ce_n_o     (mem_ce_n),
        .oe_n_o     (mem_oe_n),
        .we_n_o     (mem_we_n),
        .dq_oe_o    (mem_dq_oe)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .is_write_i (req_write),
        .capture_i  (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_i   (mem_dq_i),
        .mem_addr   (mem_addr),
        .mem_dq_o   (mem_dq_o),
        .rdata_o    (rsp_rdata)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
// Module: protocol checker for the static RAM controller, bound to its top.
// Observes ports only; keeps one saturating counter for the release gap.
module asram_ctrl_chk
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_HZ_NS       = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);

    localparam int TA = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);

    int gap_q;

    // Cycles since output enable was last low, saturating at TA
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= TA;
        else if (!mem_oe_n)
            gap_q <= 0;
        else if (gap_q < TA)
            gap_q <= gap_q + 1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_done));

    a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

    a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    a_r8_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

    a_r3_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe));

    a_r4_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && $stable(mem_addr) && $stable(mem_dq_o)));

    a_r4_stable_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> (mem_ce_n && $stable(mem_addr) && $stable(mem_dq_o)));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    a_r6_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(gap_q) >= TA));

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_HZ_NS       (T_HZ_NS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
// Bench: scoreboard driven test of the static RAM controller with a timed
// behavioural memory model. 50 MHz clock.
`timescale 1ns/1ps
module asram_ctrl_tb_top;

    localparam int PER   = 20;
    localparam int AW    = 19;
    localparam int DW    = 8;
    localparam int EXP_RD = (45 + PER - 1) / PER;
    localparam int EXP_WE = ((35 + PER - 1) / PER > 1) ? (35 + PER - 1) / PER : 1;
    localparam int EXP_TA = (15 + PER - 1) / PER;
    localparam logic [DW-1:0] JUNK = 8'hEE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n;
    logic          mem_oe_n;
    logic          mem_we_n;
    logic [DW-1:0] mem_dq_o;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_dq_i = JUNK;

    int total = 0;
    int bad   = 0;
    bit run_en = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    asram_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i)
    );

    // Counted check with one line per failure
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- timed memory model ----------------
    logic [DW-1:0] mem [logic [AW-1:0]];
    realtime t_rdchg = 0, t_addr = 0, t_data = 0;
    realtime t_we_fall = 0, t_we_rise = 0, t_oe_rise = -1000;
    bit wrote = 1'b0;

    always @(mem_addr or mem_ce_n or mem_oe_n or mem_we_n) t_rdchg = $realtime;
    always @(mem_addr) t_addr = $realtime;
    always @(mem_dq_o) t_data = $realtime;
    always @(posedge mem_oe_n) t_oe_rise = $realtime;
    always @(negedge mem_we_n) t_we_fall = $realtime;

    // Read path: data appears only after controls and address settle 45 ns
    initial begin
        #0.5;
        forever begin
            if (!mem_ce_n && !mem_oe_n && mem_we_n && ($realtime - t_rdchg >= 45.0))
                mem_dq_i = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
            else
                mem_dq_i = JUNK;
            #1;
        end
    end

    // Write path: the write ends on the strobe's rising edge
    always @(posedge mem_we_n) begin
        if (run_en && !mem_ce_n) begin
            t_we_rise = $realtime;
            check($realtime - t_we_fall >= 35.0, "R3", "strobe low ns",
                  longint'($realtime - t_we_fall), 35);
            check($realtime - t_data >= 25.0, "R3", "data setup ns",
                  longint'($realtime - t_data), 25);
            check($realtime - t_addr >= 35.0, "R3", "address setup ns",
                  longint'($realtime - t_addr), 35);
            check(mem_dq_oe == 1'b1, "R3", "drivers on at strobe end", mem_dq_oe, 1);
            mem[mem_addr] = mem_dq_o;
            wrote = 1'b1;
        end
    end

    // Hold after the strobe: nothing changes for a cycle
    always @(posedge mem_ce_n) begin
        if (run_en && wrote) begin
            wrote = 1'b0;
            check($realtime - t_we_rise >= 19.0, "R4", "strobe-to-deselect ns",
                  longint'($realtime - t_we_rise), PER);
            check(t_addr < t_we_rise && t_data < t_we_rise, "R4",
                  "address/data changed after strobe", 1, 0);
        end
    end

    // Bus release gap in time after a read
    always @(posedge mem_dq_oe) begin
        if (run_en)
            check($realtime - t_oe_rise >= 15.0, "R6", "drive after release ns",
                  longint'($realtime - t_oe_rise), 15);
    end

    // Strobe combinations every cycle
    always @(negedge clk) begin
        if (run_en) begin
            check(!(mem_dq_oe && (!mem_oe_n || mem_ce_n)), "R8", "drivers vs strobes",
                  {mem_dq_oe, mem_oe_n, mem_ce_n}, 3'b110);
            check(!mem_ce_n || (mem_oe_n && mem_we_n), "R9", "deselected strobes",
                  {mem_oe_n, mem_we_n}, 2'b11);
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { bit is_rd; logic [DW-1:0] exp; } sb_item_t;
    sb_item_t sbq[$];
    logic [DW-1:0] shadow [logic [AW-1:0]];

    // Monitor: pop one item per completion
    always @(negedge clk) begin
        if (run_en && rsp_done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R7", "completion with no accepted request", 1, 0);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                if (it.is_rd)
                    check(rsp_rdata == it.exp, "R2", "read data", rsp_rdata, it.exp);
            end
        end
    end

    // Driver: one request, with an optional stray request while busy
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit poke);
        int lat;
        sb_item_t it;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        it.is_rd = !wr;
        it.exp   = shadow.exists(a) ? shadow[a] : 8'h00;
        sbq.push_back(it);
        if (wr) shadow[a] = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (poke) begin
            check(req_ready == 1'b0, "R7", "busy after accept", req_ready, 0);
            req_valid = 1'b1; req_write = 1'b1;
            req_addr = 19'h0_0ABC; req_wdata = 8'h3C;
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
        end
        while (!rsp_done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        if (wr)
            check(lat == EXP_WE + 3, "R3", "write latency", lat, EXP_WE + 3);
        else
            check(lat == EXP_RD + 1, "R2", "read latency", lat, EXP_RD + 1);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        issue(1'b1, a, d, 1'b0);
    endtask

    // Read and measure the ready-low window that follows
    task automatic rd(input logic [AW-1:0] a);
        int ta;
        issue(1'b0, a, 8'h00, 1'b0);
        ta = 0;
        while (!req_ready && ta < 20) begin
            ta++;
            @(negedge clk);
        end
        check(ta == EXP_TA, "R6", "ready low after read", ta, EXP_TA);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes in reset",
              {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        check(!mem_dq_oe && !rsp_done, "R1", "drivers/done in reset",
              {mem_dq_oe, rsp_done}, 0);
        rst_n = 1'b1;
        run_en = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

        // Writes with varied patterns, including the address extremes
        wr(19'h0_0000, 8'h00);
        wr(19'h7_FFFF, 8'hFF);
        wr(19'h1_2345, 8'hA5);
        wr(19'h5_4321, 8'h5A);
        wr(19'h0_0ABC, 8'h81);

        // Read back; each read is followed by a write with no gap (R6)
        rd(19'h7_FFFF);
        wr(19'h2_0000, 8'h7E);
        rd(19'h0_0000);
        rd(19'h1_2345);
        rd(19'h2_0000);

        // Write then read the same address at once; then overwrite
        wr(19'h3_3333, 8'hC3);
        rd(19'h3_3333);
        wr(19'h3_3333, 8'h3C);
        rd(19'h3_3333);

        // R5: read data holds across a following write
        rd(19'h5_4321);
        wr(19'h4_0000, 8'h11);
        check(rsp_rdata == 8'h5A, "R5", "read data held over write", rsp_rdata, 8'h5A);

        // R7: a stray write to 0x00ABC while busy must not land
        issue(1'b1, 19'h6_0000, 8'h99, 1'b1);
        rd(19'h0_0ABC);
        check(rsp_rdata == 8'h81, "R7", "stray request had no effect", rsp_rdata, 8'h81);

        // R5: no leftover completions once idle
        repeat (6) @(negedge clk);
        check(sbq.size() == 0, "R5", "outstanding completions", sbq.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(PER * 20000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule